// File: doc/BRIEF.md
# Multi-channel sinc3 decimator for sigma-delta current feedback

The block takes four 1-bit sigma-delta streams from isolated modulators (the three phase currents and the DC-bus current) and turns them into signed multi-bit samples. It divides the system clock to make the one modulator clock that every modulator shares. On each modulator clock period it reads one bit per channel, and it runs a third-order sinc filter on each channel with decimation by a selectable oversampling ratio (OSR). All channels share one integrator tick and one decimation counter, so the four filters stay in lockstep.

The controller chooses the capture instant with a trigger pulse placed at a quiet point of the PWM period. On that pulse the block latches every channel at once, together with a running count of decimated results and a settled flag. The fixed group delay of the active OSR is driven on a port, so the control software can align the feedback with its own PWM edges. The OSR can be changed only while reset is held.

Each channel also has a returned copy of the modulator clock. A watchdog raises a sticky per-channel fault when no edge of that copy arrives within a programmable number of system cycles.

Top module: `sinc3_multi_decim`

## Requirements
- R1: After synchronous reset, out_data, out_count, out_valid, out_strobe and mclk_fault are all zero.
- R2: mod_clk has a period of MCLK_DIV system cycles. Counting posedges after reset release from 0, mod_clk is high when (count mod MCLK_DIV) < MCLK_DIV/2. At each edge where mod_clk rises, one bit of every channel is consumed.
- R3: A bit value of 1 counts as +1 and a bit value of 0 counts as −1. When a channel's input repeats a 4-bit pattern with n ones, a settled output equals (2n−4)/4 · OSR³.
- R4: Every channel is filtered and latched at the same instant, and the result on one channel does not depend on the inputs of another.
- R5: osr_sel is captured only while rst_n is low, with code 0→32, 1→64, 2→128 and 3→256. A change to osr_sel while running has no effect.
- R6: group_delay equals 3·OSR+3, expressed in half modulator-clock periods.
- R7: A high pwm_trig at a clock edge latches out_data, out_count and out_valid at that edge, and out_strobe is high for the following cycle only. With no trigger these outputs hold their values.
- R8: The latched out_count equals the number of decimated results produced since reset. Decimation k happens at posedge k·OSR·MCLK_DIV after release.
- R9: out_valid is low for decimated results 1 to 3 and high from result 4 onward.
- R10: When the trigger and a decimation fall on the same edge, the new result, its count and its valid flag are latched.
- R11: mclk_fault[c] becomes 1 once mclk_fb[c] has had no rising edge for fault_timeout system cycles. It stays 1 until reset and leaves the other channels unaffected.
- R12: A fault_timeout of 0 disables the fault detector, and a fault_timeout that is later made non-zero takes effect at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osr_sel | input | 2 | Oversampling ratio code, captured during reset |
| fault_timeout | input | TO_W | Cycles without a clock edge before a fault is raised (0 disables) |
| pwm_trig | input | 1 | PWM-aligned capture pulse |
| mod_clk | output | 1 | Shared modulator clock |
| mclk_fb | input | N_CH | Returned modulator clock, one per channel |
| mdat | input | N_CH | Sigma-delta bitstreams |
| out_data | output | N_CH·W | Latched signed samples, channel c at bits [c·W +: W] |
| out_strobe | output | 1 | One-cycle pulse after each capture |
| out_valid | output | 1 | Captured sample comes from a settled filter |
| out_count | output | CNT_W | Decimated result number of the captured sample |
| group_delay | output | GD_W | Filter group delay in half modulator periods |
| mclk_fault | output | N_CH | Sticky missing-clock flags |

## Verification
The capture trigger and the decimation update can land on the same clock edge. The bench provokes this by counting posedges from reset release and raising pwm_trig for edge k·OSR·MCLK_DIV exactly. It then requires the count, valid flag and data of result k. A trigger one edge earlier must still report result k−1. The check is made at the fourth result, where the valid flag and the settled value both differ from those of the third result.

// File: rtl/sinc3_multi_decim.sv
module sinc3_multi_decim #(
  parameter int N_CH        = 4,
  parameter int OSR_MIN_LOG = 5,
  parameter int MCLK_DIV    = 4,
  parameter int TO_W        = 8,
  parameter int CNT_W       = 16,
  localparam int OSR_MAX_LOG = OSR_MIN_LOG + 3,
  localparam int W           = 3 * OSR_MAX_LOG + 2,
  localparam int GD_W        = OSR_MAX_LOG + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           osr_sel,
  input  logic [TO_W-1:0]      fault_timeout,
  input  logic                 pwm_trig,
  output logic                 mod_clk,
  input  logic [N_CH-1:0]      mclk_fb,
  input  logic [N_CH-1:0]      mdat,
  output logic [N_CH*W-1:0]    out_data,
  output logic                 out_strobe,
  output logic                 out_valid,
  output logic [CNT_W-1:0]     out_count,
  output logic [GD_W-1:0]      group_delay,
  output logic [N_CH-1:0]      mclk_fault
);
  localparam int DIV_W = (MCLK_DIV > 2) ? $clog2(MCLK_DIV) : 1;
  localparam int DEC_W = OSR_MAX_LOG;

  logic [1:0]       osr_q;
  logic [DIV_W-1:0] div_cnt;
  logic [DEC_W-1:0] dec_cnt, dec_last;
  logic [1:0]       settle;
  logic             y_vld;
  logic [CNT_W-1:0] dec_total;
  logic             tick, dec_now;

  always_ff @(posedge clk)
    if (!rst_n) osr_q <= osr_sel;

  assign dec_last    = DEC_W'(({{DEC_W{1'b0}}, 1'b1} << (OSR_MIN_LOG + osr_q)) - 1'b1);
  assign group_delay = GD_W'(3 * (32'd1 << (OSR_MIN_LOG + osr_q)) + 3);
  assign mod_clk     = (div_cnt < DIV_W'(MCLK_DIV / 2));
  assign tick        = (div_cnt == DIV_W'(MCLK_DIV - 1));
  assign dec_now     = tick && (dec_cnt == dec_last);

  always_ff @(posedge clk)
    if (!rst_n) begin
      div_cnt    <= '0;
      dec_cnt    <= '0;
      settle     <= '0;
      y_vld      <= 1'b0;
      dec_total  <= '0;
      out_strobe <= 1'b0;
      out_valid  <= 1'b0;
      out_count  <= '0;
    end else begin
      div_cnt    <= tick ? '0 : div_cnt + 1'b1;
      out_strobe <= pwm_trig;
      if (tick) dec_cnt <= dec_now ? '0 : dec_cnt + 1'b1;
      if (dec_now) begin
        dec_total <= dec_total + 1'b1;
        y_vld     <= (settle == 2'd3);
        if (settle != 2'd3) settle <= settle + 1'b1;
      end
      if (pwm_trig) begin
        out_count <= dec_now ? dec_total + 1'b1 : dec_total;
        out_valid <= dec_now ? (settle == 2'd3) : y_vld;
      end
    end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic signed [W-1:0] x, i1, i2, i3, d1, d2, d3, c1, c2, c3, y_q, o_q;
    logic [2:0]          fs;
    logic [TO_W-1:0]     to_cnt;
    logic                flt;

    assign x  = mdat[c] ? W'(1) : {W{1'b1}};
    assign c1 = i3 - d1;
    assign c2 = c1 - d2;
    assign c3 = c2 - d3;

    always_ff @(posedge clk)
      if (!rst_n) begin
        i1 <= '0; i2 <= '0; i3 <= '0;
        d1 <= '0; d2 <= '0; d3 <= '0;
        y_q <= '0; o_q <= '0;
      end else begin
        if (tick) begin
          i1 <= i1 + x;
          i2 <= i2 + i1;
          i3 <= i3 + i2;
        end
        if (dec_now) begin
          d1  <= i3;
          d2  <= c1;
          d3  <= c2;
          y_q <= c3;
        end
        if (pwm_trig) o_q <= dec_now ? c3 : y_q;
      end

    always_ff @(posedge clk)
      if (!rst_n) begin
        fs     <= '0;
        to_cnt <= '0;
        flt    <= 1'b0;
      end else begin
        fs <= {fs[1:0], mclk_fb[c]};
        if (fs[2:1] == 2'b01) to_cnt <= '0;
        else if (to_cnt != '1) to_cnt <= to_cnt + 1'b1;
        if (fault_timeout != '0 && to_cnt >= fault_timeout) flt <= 1'b1;
      end

    assign out_data[c*W +: W] = o_q;
    assign mclk_fault[c]      = flt;
  end

  // R7
  trig_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_trig |=> ($stable(out_count) && $stable(out_valid)));

  // R7
  strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_strobe |-> $past(pwm_trig));

  // R9
  valid_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (settle == 2'd3));

  // R11
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mclk_fault != '0) |=> ((mclk_fault & $past(mclk_fault)) == $past(mclk_fault)));

  // R2
  modclk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> mod_clk);

  // R5
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(group_delay));
endmodule

// File: tb/tb_sinc3_multi_decim.sv
`timescale 1ns/1ps
module tb_sinc3_multi_decim;
  localparam int N   = 4;
  localparam int DIV = 4;
  localparam int W   = 26;
  localparam int TOW = 8;
  localparam int CW  = 16;
  localparam int GW  = 10;
  localparam int NV  = 6;

  localparam logic [15:0] VEC_PAT [NV] = '{16'hFFFF, 16'h0000, 16'hE50F,
                                           16'hF731, 16'h0C8A, 16'h92D6};
  localparam int VEC_EXP [NV][N] = '{
    '{ 32768,  32768,  32768,  32768},
    '{-32768, -32768, -32768, -32768},
    '{ 32768, -32768,      0,  16384},
    '{-16384,      0,  16384,  32768},
    '{     0, -16384,      0, -32768},
    '{     0,  16384, -16384,      0}};

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      osr_sel = 2'd0;
  logic [TOW-1:0]  fault_timeout = 8'd20;
  logic            pwm_trig = 1'b0;
  logic            mod_clk;
  logic [N-1:0]    fb_en = '1;
  logic [N-1:0]    mclk_fb;
  logic [N-1:0]    mdat = '0;
  logic [N*W-1:0]  out_data;
  logic            out_strobe, out_valid;
  logic [CW-1:0]   out_count;
  logic [GW-1:0]   group_delay;
  logic [N-1:0]    mclk_fault;
  logic [3:0]      pat [N];

  int  cyc = 0;
  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  assign mclk_fb = fb_en & {N{mod_clk}};

  sinc3_multi_decim #(.N_CH(N), .OSR_MIN_LOG(5), .MCLK_DIV(DIV), .TO_W(TOW), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .osr_sel(osr_sel), .fault_timeout(fault_timeout),
    .pwm_trig(pwm_trig), .mod_clk(mod_clk), .mclk_fb(mclk_fb), .mdat(mdat),
    .out_data(out_data), .out_strobe(out_strobe), .out_valid(out_valid),
    .out_count(out_count), .group_delay(group_delay), .mclk_fault(mclk_fault));

  initial forever begin
    @(posedge clk);
    if (rst_n) cyc = cyc + 1; else cyc = 0;
  end

  initial forever begin
    @(negedge clk);
    for (int c = 0; c < N; c++) mdat[c] = pat[c][(cyc / DIV) % 4];
  end

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint chan(input int c);
    return longint'($signed(out_data[c*W +: W]));
  endfunction

  task automatic set_all(input logic [3:0] p);
    for (int c = 0; c < N; c++) pat[c] = p;
  endtask

  task automatic do_reset(input logic [1:0] sel);
    @(negedge clk);
    rst_n = 1'b0;
    osr_sel = sel;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic trig_at(input int edge_n);
    while (cyc < edge_n - 1) @(negedge clk);
    pwm_trig = 1'b1;
    @(negedge clk);
    pwm_trig = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    set_all(4'hF);
    do_reset(2'd0);
    // R1: outputs right after reset release
    check("R1 strobe", out_strobe, 0);
    check("R1 valid", out_valid, 0);
    check("R1 count", out_count, 0);
    check("R1 data", longint'(out_data != '0), 0);
    check("R1 fault", mclk_fault, 0);
    check("R6 delay osr32", group_delay, 99);

    // R2: modulator clock phase
    for (int k = 0; k < 8; k++) begin
      check("R2 mod_clk", mod_clk, ((cyc % DIV) < DIV / 2) ? 1 : 0);
      @(negedge clk);
    end

    // R9, R8: result 3 is not yet settled
    trig_at(3 * 128 + 10);
    check("R7 strobe", out_strobe, 1);
    check("R8 count3", out_count, 3);
    check("R9 valid3", out_valid, 0);
    @(negedge clk);
    check("R7 strobe drop", out_strobe, 0);

    // R10: trigger on the decimation edge of result 4
    trig_at(4 * 128);
    check("R10 count", out_count, 4);
    check("R10 valid", out_valid, 1);
    check("R10 data", chan(0), 32768);
    trig_at(5 * 128 - 1);
    check("R10 early count", out_count, 4);

    // R5: osr change while running is ignored
    osr_sel = 2'd3;
    trig_at(20 * 128 + 5);
    check("R5 count", out_count, 20);
    check("R5 data", chan(1), 32768);
    check("R5 delay", group_delay, 99);

    // R3/R4: table of per-channel patterns
    for (int v = 0; v < NV; v++) begin
      for (int c = 0; c < N; c++) pat[c] = VEC_PAT[v][c*4 +: 4];
      trig_at(cyc + 6 * 128 + 37);
      check("R9 valid", out_valid, 1);
      for (int c = 0; c < N; c++) check("R3/R4 value", chan(c), VEC_EXP[v][c]);
    end

    // R11: stop channel 2 returned clock
    check("R11 no fault", mclk_fault, 0);
    fb_en = 4'b1011;
    repeat (10) @(negedge clk);
    check("R11 before timeout", mclk_fault, 0);
    repeat (30) @(negedge clk);
    check("R11 fault ch2", mclk_fault, 4'b0100);
    fb_en = '1;
    repeat (20) @(negedge clk);
    check("R11 sticky", mclk_fault, 4'b0100);

    // R12: zero timeout disables, then takes effect
    fault_timeout = '0;
    fb_en = '0;
    do_reset(2'd0);
    repeat (200) @(negedge clk);
    check("R12 disabled", mclk_fault, 0);
    fault_timeout = 8'd20;
    repeat (5) @(negedge clk);
    check("R12 enabled", mclk_fault, 4'b1111);
    fb_en = '1;

    // R5, R6, R3: other ratios
    set_all(4'hF);
    do_reset(2'd1);
    check("R6 delay osr64", group_delay, 195);
    trig_at(6 * 256 + 7);
    check("R8 count osr64", out_count, 6);
    check("R3 osr64", chan(2), 262144);

    set_all(4'hE);
    do_reset(2'd2);
    check("R6 delay osr128", group_delay, 387);
    trig_at(6 * 512 + 9);
    check("R8 count osr128", out_count, 6);
    check("R3 osr128", chan(3), 1048576);

    set_all(4'h0);
    do_reset(2'd3);
    check("R6 delay osr256", group_delay, 771);
    trig_at(5 * 1024 + 3);
    check("R8 count osr256", out_count, 5);
    check("R3 osr256", chan(0), -16777216);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule